// File: doc/BRIEF.md
# Codec command slot register interface

This block holds the slot registers through which software reads and writes registers inside an external audio codec. Software places command data in the slot-2 transmit register and then writes the slot-1 transmit register. That write launches the command at once on a request/response port facing the codec. The slot-1 word carries the direction and the codec register index. The slot-2 word carries the 16-bit value.

When a read completes, the returned value and an echo of the command word land in two receive registers. A flag register lets software see which transmit slots are empty, which receive slots are still waiting and which hold fresh data. The serial frame that carries the slots and the codec's own registers lie outside this block.

A slot-1 write that arrives while a command is still in flight is not lost. It is held back and launched once the codec reports that the current command is complete.

Top module: `codec_slot_regif`

## Requirements
- R1: After reset every data register reads 0, `cmd_req` is low, and the flag register reads 0x64. Flag bits are: 0 slot-1 receive busy, 1 slot-1 receive valid, 2 slot-1 transmit empty, 3 slot-2 receive busy, 4 slot-2 receive valid, 5 slot-2 transmit empty, 6 both transmit slots empty.
- R2: A bus write to the slot-1 transmit register (word address 0) stores bits 19:0 of the write data and clears flag bit 2. With no command pending, `cmd_req` is high from the next cycle.
- R3: Bit 19 of the slot-1 word selects the command direction: 1 is a read (`cmd_rnw` = 1) and 0 is a write.
- R4: The codec register index `cmd_index` is bits 18:12 of the slot-1 word.
- R5: The command value `cmd_wdata` is bits 19:4 of the slot-2 transmit register (word address 2).
- R6: A bus write to the slot-2 transmit register clears flag bit 5 and launches no command.
- R7: When a read completes, the slot-1 receive register (address 1) gets the launched slot-1 word with bit 19 cleared. The slot-2 receive register (address 3) gets `cmd_rdata` shifted left by 4.
- R8: While a read is outstanding, flag bits 0 and 3 are set. On completion both clear, and flag bits 1 and 4 are set.
- R9: A bus read of the slot-1 receive register clears flag bit 1. A bus read of the slot-2 receive register clears flag bit 4.
- R10: Completing a write command leaves both receive registers and the valid flags unchanged.
- R11: `cmd_req` and the command fields hold steady until `cmd_done`. A slot-1 write made while a command is pending is launched with the newer word in the second cycle after the completing cycle.
- R12: Completion sets flag bit 5. It also sets flag bit 2 unless a deferred slot-1 command is waiting. Flag bit 6 is set exactly when bits 2 and 5 are both set.
- R13: Writes to the receive registers, the flag register (address 4) or unused addresses change nothing. Reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; reading a receive register clears its valid flag |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cmd_req | output | 1 | Command outstanding toward the codec |
| cmd_rnw | output | 1 | 1 = read command, 0 = write command |
| cmd_index | output | 7 | Codec register index |
| cmd_wdata | output | 16 | Value for a write command |
| cmd_done | input | 1 | Single-cycle completion from the codec |
| cmd_rdata | input | 16 | Read value, valid with `cmd_done` |

## Verification
The embedded properties check, on every cycle, that:
- an outstanding request and its fields stay steady until completion;
- a slot-1 write on an idle port drives the direction and index bits out on the next cycle;
- the busy flags cover every outstanding read;
- completing a write never disturbs the receive registers;
- a held-back command is launched two cycles after the completion.

Only the bench scenarios can show:
- the exact receive register contents after a read, including the cleared bit 19 and the 4-bit shift;
- the flag register values through a whole command, including the empty flags;
- that writes to read-only and unused addresses are ignored;
- that the deferred command carries the newer slot-1 word rather than the one it displaced.

// File: rtl/cslot_pkg.sv
package cslot_pkg;

  // Register word addresses
  localparam int ADR_S1TX  = 0;
  localparam int ADR_S1RX  = 1;
  localparam int ADR_S2TX  = 2;
  localparam int ADR_S2RX  = 3;
  localparam int ADR_FLAGS = 4;

  // Flag register bit positions
  localparam int F_S1_BUSY  = 0;
  localparam int F_S1_VALID = 1;
  localparam int F_S1_EMPTY = 2;
  localparam int F_S2_BUSY  = 3;
  localparam int F_S2_VALID = 4;
  localparam int F_S2_EMPTY = 5;
  localparam int F_TX_EMPTY = 6;
  localparam int FLAG_W     = 7;

endpackage

// File: rtl/cslot_decode.sv
module cslot_decode #(
  parameter int SLOT_W  = 20,
  parameter int IDX_W   = 7,
  parameter int VAL_W   = 16,
  parameter int RW_BIT  = 19,
  parameter int IDX_LSB = 12,
  parameter int DAT_LSB = 4
) (
  input  logic [SLOT_W-1:0] s1_word,
  input  logic [SLOT_W-1:0] s2_word,
  output logic              rnw,
  output logic [IDX_W-1:0]  idx,
  output logic [VAL_W-1:0]  val
);

  // Direction select and register index from the slot-1 word
  assign rnw = s1_word[RW_BIT];
  assign idx = s1_word[IDX_LSB +: IDX_W];

  // Command value from the slot-2 word
  assign val = s2_word[DAT_LSB +: VAL_W];

  logic unused_bits;
  assign unused_bits = ^{s1_word[IDX_LSB-1:0], s2_word[DAT_LSB-1:0]};

endmodule

// File: rtl/cslot_issue.sv
module cslot_issue #(
  parameter int SLOT_W  = 20,
  parameter int IDX_W   = 7,
  parameter int VAL_W   = 16,
  parameter int RW_BIT  = 19,
  parameter int IDX_LSB = 12,
  parameter int DAT_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_s1,
  input  logic [SLOT_W-1:0] wr_word,
  input  logic [SLOT_W-1:0] s1_reg,
  input  logic [SLOT_W-1:0] s2_reg,
  input  logic              cmd_done,
  output logic              cmd_req,
  output logic              cmd_rnw,
  output logic [IDX_W-1:0]  cmd_idx,
  output logic [VAL_W-1:0]  cmd_val,
  output logic [SLOT_W-1:0] cmd_word,
  output logic              launch,
  output logic              launch_rnw,
  output logic              finish,
  output logic              defer_q
);

  logic              pend_q, pend_d;
  logic              defer_d;
  logic              rnw_q;
  logic [IDX_W-1:0]  idx_q;
  logic [VAL_W-1:0]  val_q;
  logic [SLOT_W-1:0] word_q;

  logic [SLOT_W-1:0] src_word;
  logic              rnw_n;
  logic [IDX_W-1:0]  idx_n;
  logic [VAL_W-1:0]  val_n;

  // A fresh bus write takes priority over a held-back one
  assign src_word = wr_s1 ? wr_word : s1_reg;

  cslot_decode #(
    .SLOT_W(SLOT_W), .IDX_W(IDX_W), .VAL_W(VAL_W),
    .RW_BIT(RW_BIT), .IDX_LSB(IDX_LSB), .DAT_LSB(DAT_LSB)
  ) u_dec (
    .s1_word(src_word),
    .s2_word(s2_reg),
    .rnw    (rnw_n),
    .idx    (idx_n),
    .val    (val_n)
  );

  assign launch     = !pend_q && (wr_s1 || defer_q);
  assign launch_rnw = rnw_n;
  assign finish     = pend_q && cmd_done;

  always_comb begin
    pend_d  = pend_q;
    defer_d = defer_q;
    if (launch) begin
      pend_d  = 1'b1;
      defer_d = 1'b0;
    end else begin
      if (finish)           pend_d  = 1'b0;
      if (wr_s1 && pend_q)  defer_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      defer_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      defer_q <= defer_d;
    end
  end

  // Command fields are loaded only on launch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rnw_q  <= 1'b0;
      idx_q  <= '0;
      val_q  <= '0;
      word_q <= '0;
    end else if (launch) begin
      rnw_q  <= rnw_n;
      idx_q  <= idx_n;
      val_q  <= val_n;
      word_q <= src_word;
    end
  end

  assign cmd_req  = pend_q;
  assign cmd_rnw  = rnw_q;
  assign cmd_idx  = idx_q;
  assign cmd_val  = val_q;
  assign cmd_word = word_q;

  // R11: the request and its fields hold until the codec completes it
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_done) |=> (cmd_req && $stable(cmd_idx) &&
                                $stable(cmd_rnw) && $stable(cmd_val)));

  // R11: a held-back slot-1 write is launched in the second cycle after completion
  p_defer_issue_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_done && (defer_q || wr_s1)) |=> ##1 cmd_req);

endmodule

// File: rtl/cslot_flags.sv
module cslot_flags
  import cslot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_s1,
  input  logic              wr_s2,
  input  logic [1:0]        rd_rx,
  input  logic              launch,
  input  logic              launch_rnw,
  input  logic              finish,
  input  logic              finish_rnw,
  input  logic              defer_q,
  output logic [FLAG_W-1:0] flags
);

  logic [1:0] busy_q, busy_d;
  logic [1:0] valid_q, valid_d;
  logic       e1_q, e1_d;
  logic       e2_q, e2_d;

  // Both receive slots share one busy/valid protocol
  for (genvar g = 0; g < 2; g++) begin : g_rx
    always_comb begin
      busy_d[g] = busy_q[g];
      if (launch && launch_rnw) busy_d[g] = 1'b1;
      else if (finish)          busy_d[g] = 1'b0;

      valid_d[g] = valid_q[g];
      if (finish && finish_rnw) valid_d[g] = 1'b1;
      else if (rd_rx[g])        valid_d[g] = 1'b0;
    end
  end

  always_comb begin
    e1_d = e1_q;
    if (wr_s1)                  e1_d = 1'b0;
    else if (finish && !defer_q) e1_d = 1'b1;

    e2_d = e2_q;
    if (wr_s2)       e2_d = 1'b0;
    else if (finish) e2_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      valid_q <= '0;
      e1_q    <= 1'b1;
      e2_q    <= 1'b1;
    end else begin
      busy_q  <= busy_d;
      valid_q <= valid_d;
      e1_q    <= e1_d;
      e2_q    <= e2_d;
    end
  end

  always_comb begin
    flags             = '0;
    flags[F_S1_BUSY]  = busy_q[0];
    flags[F_S1_VALID] = valid_q[0];
    flags[F_S1_EMPTY] = e1_q;
    flags[F_S2_BUSY]  = busy_q[1];
    flags[F_S2_VALID] = valid_q[1];
    flags[F_S2_EMPTY] = e2_q;
    flags[F_TX_EMPTY] = e1_q && e2_q;
  end

endmodule

// File: rtl/codec_slot_regif.sv
module codec_slot_regif
  import cslot_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int ADDR_W  = 3,
  parameter int SLOT_W  = 20,
  parameter int IDX_W   = 7,
  parameter int VAL_W   = 16,
  parameter int RW_BIT  = 19,
  parameter int IDX_LSB = 12,
  parameter int DAT_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              cmd_req,
  output logic              cmd_rnw,
  output logic [IDX_W-1:0]  cmd_index,
  output logic [VAL_W-1:0]  cmd_wdata,
  input  logic              cmd_done,
  input  logic [VAL_W-1:0]  cmd_rdata
);

  localparam logic [SLOT_W-1:0] RW_MASK = SLOT_W'(1) << RW_BIT;

  // Asynchronous assert, synchronous release
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  logic wr_s1, wr_s2;
  logic [1:0] rd_rx;
  assign wr_s1    = bus_wr && (bus_addr == ADDR_W'(ADR_S1TX));
  assign wr_s2    = bus_wr && (bus_addr == ADDR_W'(ADR_S2TX));
  assign rd_rx[0] = bus_rd && (bus_addr == ADDR_W'(ADR_S1RX));
  assign rd_rx[1] = bus_rd && (bus_addr == ADDR_W'(ADR_S2RX));

  logic [SLOT_W-1:0] s1tx_q, s1tx_d, s2tx_q, s2tx_d;
  logic [SLOT_W-1:0] rx1_q, rx1_d, rx2_q, rx2_d;
  logic [SLOT_W-1:0] cmd_word;
  logic              launch, launch_rnw, finish, defer_q;
  logic [FLAG_W-1:0] flags;

  cslot_issue #(
    .SLOT_W(SLOT_W), .IDX_W(IDX_W), .VAL_W(VAL_W),
    .RW_BIT(RW_BIT), .IDX_LSB(IDX_LSB), .DAT_LSB(DAT_LSB)
  ) u_issue (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_s1     (wr_s1),
    .wr_word   (bus_wdata[SLOT_W-1:0]),
    .s1_reg    (s1tx_q),
    .s2_reg    (s2tx_q),
    .cmd_done  (cmd_done),
    .cmd_req   (cmd_req),
    .cmd_rnw   (cmd_rnw),
    .cmd_idx   (cmd_index),
    .cmd_val   (cmd_wdata),
    .cmd_word  (cmd_word),
    .launch    (launch),
    .launch_rnw(launch_rnw),
    .finish    (finish),
    .defer_q   (defer_q)
  );

  cslot_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_s1     (wr_s1),
    .wr_s2     (wr_s2),
    .rd_rx     (rd_rx),
    .launch    (launch),
    .launch_rnw(launch_rnw),
    .finish    (finish),
    .finish_rnw(cmd_rnw),
    .defer_q   (defer_q),
    .flags     (flags)
  );

  always_comb begin
    s1tx_d = wr_s1 ? bus_wdata[SLOT_W-1:0] : s1tx_q;
    s2tx_d = wr_s2 ? bus_wdata[SLOT_W-1:0] : s2tx_q;
    rx1_d  = rx1_q;
    rx2_d  = rx2_q;
    if (finish && cmd_rnw) begin
      rx1_d = cmd_word & ~RW_MASK;
      rx2_d = SLOT_W'(cmd_rdata) << DAT_LSB;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      s1tx_q <= '0;
      s2tx_q <= '0;
      rx1_q  <= '0;
      rx2_q  <= '0;
    end else begin
      s1tx_q <= s1tx_d;
      s2tx_q <= s2tx_d;
      rx1_q  <= rx1_d;
      rx2_q  <= rx2_d;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(ADR_S1TX):  bus_rdata = BUS_W'(s1tx_q);
      ADDR_W'(ADR_S1RX):  bus_rdata = BUS_W'(rx1_q);
      ADDR_W'(ADR_S2TX):  bus_rdata = BUS_W'(s2tx_q);
      ADDR_W'(ADR_S2RX):  bus_rdata = BUS_W'(rx2_q);
      ADDR_W'(ADR_FLAGS): bus_rdata = BUS_W'(flags);
      default:            bus_rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[BUS_W-1:SLOT_W];

  // R3, R4: a slot-1 write on an idle port drives direction and index out
  p_launch_fields_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_s1 && !cmd_req) |=> (cmd_req &&
      cmd_rnw == $past(bus_wdata[RW_BIT]) &&
      cmd_index == $past(bus_wdata[IDX_LSB +: IDX_W])));

  // R8: an outstanding read always shows both busy flags
  p_busy_held_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_req && cmd_rnw) |-> (flags[F_S1_BUSY] && flags[F_S2_BUSY]));

  // R8: read completion swaps busy for valid
  p_read_done_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_req && cmd_rnw && cmd_done) |=>
      (flags[F_S1_VALID] && flags[F_S2_VALID] &&
       !flags[F_S1_BUSY] && !flags[F_S2_BUSY]));

  // R9: reading the slot-1 receive register drops its valid flag
  p_valid_clear_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_rx[0] && !(cmd_req && cmd_done && cmd_rnw)) |=> !flags[F_S1_VALID]);

  // R10: write completion leaves the receive registers alone
  p_write_keeps_rx_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_req && !cmd_rnw && cmd_done) |=> ($stable(rx1_q) && $stable(rx2_q)));

endmodule

// File: tb/codec_slot_regif_test.sv
module codec_slot_regif_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        cmd_req, cmd_rnw, cmd_done;
  logic [6:0]  cmd_index;
  logic [15:0] cmd_wdata, cmd_rdata;

  always #5 clk = ~clk;

  codec_slot_regif uut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_req(cmd_req), .cmd_rnw(cmd_rnw), .cmd_index(cmd_index),
    .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata)
  );

  typedef struct packed {
    logic [31:0] s2;
    logic [31:0] s1;
    logic [15:0] rd;
    logic        rnw;
    logic [6:0]  idx;
    logic [15:0] wd;
    logic [19:0] rx1;
    logic [19:0] rx2;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{32'h0001_2340, 32'h0000_2000, 16'h0000, 1'b0, 7'h02, 16'h1234, 20'h0, 20'h0},
    '{32'h000A_BCD5, 32'h000F_F00A, 16'h5A5A, 1'b1, 7'h7F, 16'hABCD, 20'h7F00A, 20'h5A5A0},
    '{32'h0000_0000, 32'h0009_C123, 16'hFFFF, 1'b1, 7'h1C, 16'h0000, 20'h1C123, 20'hFFFF0},
    '{32'h000F_FFFF, 32'h00F7_F000, 16'h0000, 1'b0, 7'h7F, 16'hFFFF, 20'h0, 20'h0},
    '{32'h0000_0010, 32'h0008_0000, 16'h0001, 1'b1, 7'h00, 16'h0001, 20'h00000, 20'h00010}
  };

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic codec_reply(input logic [15:0] v);
    @(negedge clk);
    cmd_done = 1'b1; cmd_rdata = v;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [19:0] exp_rx1, exp_rx2;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    cmd_done = 0; cmd_rdata = 0;
    do_reset();

    // R1: reset state
    chk("R1 cmd_req", 32'(cmd_req), 0);
    for (int a = 0; a < 4; a++) begin
      bus_read(3'(a), d);
      chk("R1 data reg", d, 0);
    end
    bus_read(3'd4, d);
    chk("R1 flags", d, 32'h64);
    exp_rx1 = '0; exp_rx2 = '0;

    // Table walk: R2..R10, R12
    for (int i = 0; i < NV; i++) begin
      bus_write(3'd2, VEC[i].s2);
      chk("R6 no launch", 32'(cmd_req), 0);
      bus_read(3'd4, d);
      chk("R6 flags after slot-2 write", d, 32'h04);
      bus_write(3'd0, VEC[i].s1);
      chk("R2 request", 32'(cmd_req), 1);
      chk("R3 direction", 32'(cmd_rnw), 32'(VEC[i].rnw));
      chk("R4 index", 32'(cmd_index), 32'(VEC[i].idx));
      chk("R5 value", 32'(cmd_wdata), 32'(VEC[i].wd));
      bus_read(3'd0, d);
      chk("R2 slot-1 readback", d, VEC[i].s1 & 32'hFFFFF);
      bus_read(3'd4, d);
      chk("R8 flags while pending", d, VEC[i].rnw ? 32'h09 : 32'h00);
      codec_reply(VEC[i].rd);
      chk("R11 request drops", 32'(cmd_req), 0);
      bus_read(3'd4, d);
      chk("R12 flags after done", d, VEC[i].rnw ? 32'h76 : 32'h64);
      if (VEC[i].rnw) begin
        exp_rx1 = VEC[i].rx1; exp_rx2 = VEC[i].rx2;
      end
      bus_read(3'd1, d);
      chk(VEC[i].rnw ? "R7 slot-1 rx" : "R10 slot-1 rx kept", d, 32'(exp_rx1));
      bus_read(3'd4, d);
      chk("R9 slot-1 valid cleared", d, VEC[i].rnw ? 32'h74 : 32'h64);
      bus_read(3'd3, d);
      chk(VEC[i].rnw ? "R7 slot-2 rx" : "R10 slot-2 rx kept", d, 32'(exp_rx2));
      bus_read(3'd4, d);
      chk("R9 slot-2 valid cleared", d, 32'h64);
    end

    // R13: read-only and unused addresses
    bus_write(3'd1, 32'hFFFFF);
    bus_write(3'd3, 32'hFFFFF);
    bus_write(3'd4, 32'h0);
    bus_write(3'd6, 32'h12345);
    chk("R13 no launch", 32'(cmd_req), 0);
    bus_read(3'd1, d); chk("R13 slot-1 rx", d, 32'(exp_rx1));
    bus_read(3'd3, d); chk("R13 slot-2 rx", d, 32'(exp_rx2));
    bus_read(3'd4, d); chk("R13 flags", d, 32'h64);
    bus_read(3'd6, d); chk("R13 unused read", d, 0);

    // R11: deferred slot-1 write
    bus_write(3'd2, 32'h0000_0050);
    bus_write(3'd0, 32'h0009_1000);
    bus_write(3'd0, 32'h0002_2000);
    chk("R11 first cmd kept index", 32'(cmd_index), 32'h11);
    chk("R11 first cmd kept dir", 32'(cmd_rnw), 1);
    codec_reply(16'h1357);
    chk("R11 gap after done", 32'(cmd_req), 0);
    @(negedge clk);
    chk("R11 deferred launched", 32'(cmd_req), 1);
    chk("R11 deferred index", 32'(cmd_index), 32'h22);
    chk("R11 deferred dir", 32'(cmd_rnw), 0);
    chk("R11 deferred value", 32'(cmd_wdata), 32'h0005);
    bus_read(3'd4, d);
    chk("R12 slot-1 stays non-empty", d, 32'h32);
    codec_reply(16'hAAAA);
    bus_read(3'd4, d);
    chk("R12 flags after deferred done", d, 32'h76);
    bus_read(3'd1, d); chk("R7 first cmd echo", d, 32'h11000);
    bus_read(3'd3, d); chk("R7 first cmd data", d, 32'h13570);

    // R1: reset from a dirty state
    bus_write(3'd2, 32'h000F_FFFF);
    do_reset();
    bus_read(3'd2, d); chk("R1 slot-2 after reset", d, 0);
    bus_read(3'd4, d); chk("R1 flags after reset", d, 32'h64);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule